// File: doc/BRIEF.md
# Indirect Register Access Window

This block puts a single 64-bit command word in front of a small bank of 8-bit registers that belong to a two-wire serial engine. The host never addresses those registers directly. It writes one word that carries a go flag, a direction flag, an opcode, a 3-bit internal address and the data. The window then performs the internal access over a fixed number of cycles. When the access is done, it drops the go flag. The host polls that flag. On a read, it picks up the result from the low byte of the same word.

Two opcodes act. The extended-access opcode (6) reaches the data, control, clock-control/status and reset registers. The clock-phase opcode (4) loads the engine's high-phase count straight from the word's low bits. Every other bit the host writes is kept, reads back unchanged, and has no effect. While an access is in flight, the window reports busy and drops any further host writes.

Top module: `iw_window`

## Requirements
- R1: After reset, the command word reads back as all zeros, busy is low, the data, control and clock-control registers are 0, the high-phase count equals its reset parameter (24 by default), and the engine reset strobe is low.
- R2: A host write with bit 63 set starts an access. Bit 63 and busy then stay high for exactly ACC_LAT clock cycles (2 by default) and then clear together.
- R3: A host write that arrives while bit 63 is set has no effect. This holds in every busy cycle, including the cycle whose edge completes the access. The completed word and the registers reflect only the original command.
- R4: With opcode 6 in bits 60:57 and bit 56 clear, the access writes the low byte to the addressed register. Internal address 1 (bits 34:32) selects data, 2 selects control and 3 selects clock-control. All other word bits read back as written, with only bit 63 cleared.
- R5: With opcode 6 and bit 56 set, the access returns the addressed register in bits 7:0 and clears bits 31:8. Address 1 returns data, 2 returns control and 3 returns the engine status input as sampled at the completing edge. Bits 63:32 other than bit 63 are kept.
- R6: An opcode-6 write to internal address 7 raises the engine reset strobe for exactly one cycle, right after completion, whatever the data. It changes no register.
- R7: An opcode-4 write loads the high-phase count from bits 7:0. An opcode-4 read returns the current count in bits 7:0, with bits 31:8 cleared.
- R8: Opcodes other than 4 and 6, and opcode-6 writes to addresses 0, 4, 5 and 6, change no register. For these opcodes the word completes with only bit 63 cleared. Opcode-6 reads of those addresses return 0 in bits 31:0.
- R9: A host write with bit 63 clear, while idle, stores the word exactly as written. It starts no access, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Current command word, including results |
| busy | output | 1 | Access in flight; host writes are dropped |
| eng_stat_i | input | 8 | Status byte from the serial engine |
| data_o | output | 8 | Data register |
| ctrl_o | output | 8 | Control register |
| clkctl_o | output | 8 | Clock-control register |
| thp_o | output | 8 | Clock high-phase count |
| eng_rst_o | output | 1 | One-cycle engine reset strobe |

## Verification
A host write and the completion of an access can share one clock edge. In that edge the go flag is still set, so the write must be dropped, even though the word changes in that same edge. The bench provokes this by holding the write strobe high, with a different word, through every busy cycle, including the last. It then checks three things: the completed word matches the original command with its result, the register holds only the original data, and busy is low the cycle after. A second collision comes from changing the engine status input between reads, so that the status read shows the byte present at the completing edge.

// File: rtl/iw_pkg.sv
package iw_pkg;
  localparam int WORD_W = 64;
  localparam int GO_BIT = 63;
  localparam int RD_BIT = 56;
  localparam int OP_LSB = 57;
  localparam int IA_LSB = 32;

  localparam logic [3:0] OP_EXT = 4'd6;
  localparam logic [3:0] OP_THP = 4'd4;

  localparam logic [2:0] IA_DATA = 3'd1;
  localparam logic [2:0] IA_CTRL = 3'd2;
  localparam logic [2:0] IA_CLKS = 3'd3;
  localparam logic [2:0] IA_RST  = 3'd7;

  function automatic logic [3:0] iw_op(input logic [WORD_W-1:0] w);
    return w[OP_LSB +: 4];
  endfunction

  function automatic logic [2:0] iw_ia(input logic [WORD_W-1:0] w);
    return w[IA_LSB +: 3];
  endfunction

  // Word as it stands once the access is over: go cleared, read result merged.
  function automatic logic [WORD_W-1:0] iw_retire(input logic [WORD_W-1:0] w,
                                                  input logic [7:0] rv,
                                                  input logic has_rd);
    logic [WORD_W-1:0] o;
    o = w;
    o[GO_BIT] = 1'b0;
    if (has_rd && w[RD_BIT]) o[31:0] = {24'd0, rv};
    return o;
  endfunction
endpackage

// File: rtl/iw_timer.sv
module iw_timer #(
  parameter int LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start)           cnt_q <= CW'(LAT);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/iw_cmd_hold.sv
module iw_cmd_hold
  import iw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              done,
  input  logic [7:0]        rd_val,
  input  logic              rd_hit,
  output logic [WORD_W-1:0] cmd_q,
  output logic              start
);
  logic accept;

  assign accept = host_we && !cmd_q[GO_BIT];
  assign start  = accept && host_wdata[GO_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)      cmd_q <= '0;
    else if (accept) cmd_q <= host_wdata;
    else if (done)   cmd_q <= iw_retire(cmd_q, rd_val, rd_hit);
  end
endmodule

// File: rtl/iw_regbank.sv
module iw_regbank
  import iw_pkg::*;
#(
  parameter logic [7:0] THP_RST = 8'd24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  logic [3:0] op,
  input  logic       rd,
  input  logic [2:0] ia,
  input  logic [7:0] lo,
  input  logic [7:0] eng_stat_i,
  output logic [7:0] data_q,
  output logic [7:0] ctrl_q,
  output logic [7:0] clkctl_q,
  output logic [7:0] thp_q,
  output logic       eng_rst_q,
  output logic [7:0] rd_val,
  output logic       rd_hit
);
  logic wr_ext, wr_thp;

  assign wr_ext = done && !rd && (op == OP_EXT);
  assign wr_thp = done && !rd && (op == OP_THP);
  assign rd_hit = (op == OP_EXT) || (op == OP_THP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      ctrl_q    <= '0;
      clkctl_q  <= '0;
      thp_q     <= THP_RST;
      eng_rst_q <= 1'b0;
    end else begin
      eng_rst_q <= wr_ext && (ia == IA_RST);
      if (wr_thp) thp_q <= lo;
      if (wr_ext) begin
        case (ia)
          IA_DATA: data_q   <= lo;
          IA_CTRL: ctrl_q   <= lo;
          IA_CLKS: clkctl_q <= lo;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_val = 8'd0;
    if (op == OP_THP) rd_val = thp_q;
    else if (op == OP_EXT) begin
      case (ia)
        IA_DATA: rd_val = data_q;
        IA_CTRL: rd_val = ctrl_q;
        IA_CLKS: rd_val = eng_stat_i;
        default: rd_val = 8'd0;
      endcase
    end
  end
endmodule

// File: rtl/iw_window.sv
module iw_window
  import iw_pkg::*;
#(
  parameter int         ACC_LAT = 2,
  parameter logic [7:0] THP_RST = 8'd24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [63:0] host_wdata,
  output logic [63:0] host_rdata,
  output logic        busy,
  input  logic [7:0]  eng_stat_i,
  output logic [7:0]  data_o,
  output logic [7:0]  ctrl_o,
  output logic [7:0]  clkctl_o,
  output logic [7:0]  thp_o,
  output logic        eng_rst_o
);
  logic [WORD_W-1:0] cmd_q;
  logic              acc_start, acc_done;
  logic [7:0]        rd_val;
  logic              rd_hit;

  iw_timer #(.LAT(ACC_LAT)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(acc_start), .done(acc_done)
  );

  iw_cmd_hold u_cmd (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
    .done(acc_done), .rd_val(rd_val), .rd_hit(rd_hit),
    .cmd_q(cmd_q), .start(acc_start)
  );

  iw_regbank #(.THP_RST(THP_RST)) u_bank (
    .clk(clk), .rst_n(rst_n), .done(acc_done),
    .op(iw_op(cmd_q)), .rd(cmd_q[RD_BIT]), .ia(iw_ia(cmd_q)), .lo(cmd_q[7:0]),
    .eng_stat_i(eng_stat_i),
    .data_q(data_o), .ctrl_q(ctrl_o), .clkctl_q(clkctl_o), .thp_q(thp_o),
    .eng_rst_q(eng_rst_o), .rd_val(rd_val), .rd_hit(rd_hit)
  );

  assign host_rdata = cmd_q;
  assign busy       = cmd_q[GO_BIT];
endmodule

// File: rtl/iw_window_chk.sv
module iw_window_chk #(
  parameter int LAT = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic        wr_go,
  input logic [63:0] host_rdata,
  input logic        busy,
  input logic [7:0]  data_o,
  input logic [7:0]  ctrl_o,
  input logic [7:0]  clkctl_o,
  input logic [7:0]  thp_o,
  input logic        eng_rst_o,
  input logic        acc_done
);
  int busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
    else           busy_cnt <= 0;
  end

  // R2: busy never outlasts the access latency
  a_r2_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_cnt < LAT);

  // R2: busy clears only after exactly LAT cycles
  a_r2_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(busy_cnt) == LAT - 1);

  // R3: word frozen while busy and not in the completing cycle
  a_r3_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_cnt < LAT - 1) |=> $stable(host_rdata));

  // R4: registers move only on a completing edge
  a_r4_regs_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_done |=> ($stable(data_o) && $stable(ctrl_o) && $stable(clkctl_o) && $stable(thp_o)));

  // R6: strobe lasts one cycle and follows a completion
  a_r6_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst_o |=> !eng_rst_o);

  a_r6_rst_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_rst_o) |-> $past(acc_done));

  // R9: a word without go leaves the window idle
  a_r9_no_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && host_we && !wr_go) |=> !busy);
endmodule

bind iw_window iw_window_chk #(.LAT(ACC_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .wr_go(host_wdata[63]),
  .host_rdata(host_rdata), .busy(busy), .data_o(data_o), .ctrl_o(ctrl_o),
  .clkctl_o(clkctl_o), .thp_o(thp_o), .eng_rst_o(eng_rst_o), .acc_done(acc_done)
);

// File: tb/tb_iw_window.sv
module tb_iw_window;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic        busy;
  logic [7:0]  eng_stat_i = 8'h00;
  logic [7:0]  data_o, ctrl_o, clkctl_o, thp_o;
  logic        eng_rst_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] m_data = 8'h00, m_ctrl = 8'h00, m_clk = 8'h00, m_thp = 8'd24;

  iw_window #(.ACC_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .busy(busy), .eng_stat_i(eng_stat_i),
    .data_o(data_o), .ctrl_o(ctrl_o), .clkctl_o(clkctl_o), .thp_o(thp_o),
    .eng_rst_o(eng_rst_o)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [63:0] mk(input logic go, input logic [3:0] op, input logic rd,
                                     input logic [2:0] ia, input logic [31:0] d);
    logic [63:0] w;
    w = 64'h0;
    w[63] = go;
    w[62] = 1'b1;           // undecoded bit, kept
    w[45:40] = {ia, op[2:0]}; // undecoded bits, kept
    w[60:57] = op;
    w[56] = rd;
    w[34:32] = ia;
    w[31:0] = d;
    return w;
  endfunction

  function automatic logic [63:0] done_word(input logic [63:0] w, input logic [7:0] v);
    logic [63:0] e;
    e = w;
    e[63] = 1'b0;
    if (w[56] && (w[60:57] == 4'd4 || w[60:57] == 4'd6)) e[31:0] = {24'd0, v};
    return e;
  endfunction

  task automatic issue(input logic [63:0] w, output int lat, output logic rst_seen);
    @(negedge clk);
    host_we = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_we = 1'b0;
    lat = 0;
    while (busy && lat < 100) begin
      lat++;
      @(negedge clk);
    end
    rst_seen = eng_rst_o;
  endtask

  task automatic check_regs(input string req);
    check(req, {56'd0, data_o}, {56'd0, m_data});
    check(req, {56'd0, ctrl_o}, {56'd0, m_ctrl});
    check(req, {56'd0, clkctl_o}, {56'd0, m_clk});
    check(req, {56'd0, thp_o}, {56'd0, m_thp});
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int lat;
    logic rs;
    logic [63:0] w, w2;
    logic [7:0] v;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 word", host_rdata, 64'h0);
    check("R1 busy", {63'd0, busy}, 64'd0);
    check("R1 strobe", {63'd0, eng_rst_o}, 64'd0);
    check_regs("R1 regs");

    // R4 R6 R8: write sweep over every internal address
    for (int a = 0; a < 8; a++) begin
      v = 8'h30 + 8'(a * 7);
      w = mk(1'b1, 4'd6, 1'b0, 3'(a), {24'hABCDEF, v});
      issue(w, lat, rs);
      check("R2 latency", 64'(lat), 64'(LAT));
      if (a == 1) m_data = v;
      if (a == 2) m_ctrl = v;
      if (a == 3) m_clk = v;
      check("R4 write word", host_rdata, done_word(w, 8'h00));
      check_regs("R4/R8 write regs");
      check("R6 strobe", {63'd0, rs}, {63'd0, (a == 7)});
      @(negedge clk);
      check("R6 strobe single", {63'd0, eng_rst_o}, 64'd0);
    end

    // R5 R8: read sweep, status input varies per address
    for (int a = 0; a < 8; a++) begin
      eng_stat_i = 8'hA0 + 8'(a);
      w = mk(1'b1, 4'd6, 1'b1, 3'(a), 32'h5555AAAA);
      case (a)
        1: v = m_data;
        2: v = m_ctrl;
        3: v = eng_stat_i;
        default: v = 8'h00;
      endcase
      issue(w, lat, rs);
      check("R5 read word", host_rdata, done_word(w, v));
      check_regs("R5 read no change");
    end

    // R7: high-phase load and read-back
    w = mk(1'b1, 4'd4, 1'b0, 3'd0, 32'h0000005C);
    issue(w, lat, rs);
    m_thp = 8'h5C;
    check_regs("R7 load");
    w = mk(1'b1, 4'd4, 1'b1, 3'd5, 32'hFFFFFFFF);
    issue(w, lat, rs);
    check("R7 read", host_rdata, done_word(w, 8'h5C));

    // R8: inactive opcodes, both directions
    for (int op = 0; op < 16; op++) begin
      if (op == 4 || op == 6) continue;
      for (int r = 0; r < 2; r++) begin
        w = mk(1'b1, 4'(op), r[0], 3'd1, 32'h000000EE);
        issue(w, lat, rs);
        check("R8 opcode word", host_rdata, done_word(w, 8'h00));
        check("R8 opcode strobe", {63'd0, rs}, 64'd0);
      end
      check_regs("R8 opcode regs");
    end

    // R3: host keeps writing through every busy cycle, completing edge included
    w  = mk(1'b1, 4'd6, 1'b0, 3'd1, 32'h00000011);
    w2 = mk(1'b1, 4'd6, 1'b0, 3'd1, 32'h00000022);
    @(negedge clk);
    host_we = 1'b1;
    host_wdata = w;
    for (int i = 0; i < LAT; i++) begin
      @(negedge clk);
      check("R3 busy during", {63'd0, busy}, 64'd1);
      host_wdata = w2;
      host_we = 1'b1;
    end
    @(negedge clk);
    host_we = 1'b0;
    m_data = 8'h11;
    check("R3 busy after", {63'd0, busy}, 64'd0);
    check("R3 word", host_rdata, done_word(w, 8'h00));
    check_regs("R3 regs");

    // R9: word without go is stored verbatim, no access
    w = mk(1'b0, 4'd6, 1'b0, 3'd1, 32'h00000099);
    issue(w, lat, rs);
    check("R9 latency", 64'(lat), 64'd0);
    check("R9 word", host_rdata, w);
    @(negedge clk);
    check("R9 busy", {63'd0, busy}, 64'd0);
    check_regs("R9 regs");

    finish_run();
  end
endmodule